// File: doc/BRIEF.md
# Reset Sequencer with Cause Recording

This block produces the chip-wide reset from four requesters: a power-on pulse, an external reset pin, a low-voltage reset pin and a watchdog request. It runs entirely on the slow reference clock. The two pins must stay asserted for a fixed number of slow-clock samples before they count. The power-on pulse and the watchdog request act at once. Once every requester has gone away, the reset is held for a fixed stretch before the core is let go. A boot-mode pin is sampled a fixed number of cycles ahead of that release. The sampled value tells the core whether its first fetch goes to internal ROM or to the external memory on chip select 0.

A 32-bit status/configuration word shows which requester caused the latest reset. It also holds the clock-output enable and the clock-output source select, which drive an external clock multiplexer. Any write to the word wipes the recorded cause. The word is only ever read or written as a whole.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_i` is high, `core_rst` is 1 and `cfg_rdata` reads 0x0000_0002 (power-on cause only, clock-output enable and select both 0). `core_rst` falls after the 8th rising edge following the fall of `por_i`.
- R2: An active-low pin (`ext_rst_n` or `lv_rst_n`) counts only after it has been sampled low on 4 consecutive edges. A low pulse of 3 samples leaves `core_rst`, the status bits and the clock-output select unchanged.
- R3: `core_rst` stays 1 until 8 edges have passed with no active request, and then falls. A request that arrives during the stretch restarts the count from zero.
- R4: A watchdog request needs no qualification. A single sampled cycle of `wdog_req` raises `core_rst` after that edge.
- R5: `boot_sel` takes the value of `boot_pin` sampled at the edge that lies 4 edges before the edge on which `core_rst` falls. At all other times `boot_sel` holds its value.
- R6: Status bits: bit 0 = watchdog, bit 1 = power-on, bit 2 = external pin, bit 3 = low-voltage pin. Only the cause of the most recent reset episode is set. When causes start together, the priority is power-on, then low-voltage pin, then external pin, then watchdog.
- R7: A write clears all status bits. The same write loads the clock-output enable from bit 8 and the select from bit 9 of `cfg_wdata`. All other bits read as 0.
- R8: A qualified external or low-voltage pin clears the clock-output select. A watchdog reset does not clear it. Only power-on clears the clock-output enable.
- R9: `rst_out_n` is always the inverse of `core_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow reference clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, synchronous to clk_slow |
| lv_rst_n | input | 1 | Low-voltage reset pin, active low, synchronous to clk_slow |
| wdog_req | input | 1 | Watchdog reset request, active high |
| boot_pin | input | 1 | Boot-mode pin |
| cfg_wr | input | 1 | Write strobe for the status/configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the status/configuration word |
| core_rst | output | 1 | Core reset, active high |
| rst_out_n | output | 1 | Reset output pin, active low |
| boot_sel | output | 1 | Latched boot mode (1 = external memory) |
| clkout_en | output | 1 | Clock-output enable |
| clkout_sel | output | 1 | Clock-output source (0 = fast, 1 = slow reference) |

## Verification
The bench measures how many sampled cycles `core_rst` stays high for pin pulses of exactly the qualification length, one short of it, and longer. A qualifier that is off by one either fires on the 3-sample pulse or lengthens every pin reset by a cycle. A watchdog request fired again in the middle of the stretch must lengthen the reset to 12 cycles; a stretcher that ignores the restart would give 8. The boot pin is pulsed high only in the single capture cycle, and then low only in that cycle, so sampling one edge early or late gives the opposite value. Simultaneous pin resets, and a write followed by pin or watchdog resets, show whether the priority or the select clearing is wrong.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  // Status/configuration word layout
  localparam int unsigned BIT_WDR  = 0;
  localparam int unsigned BIT_POR  = 1;
  localparam int unsigned BIT_EXT  = 2;
  localparam int unsigned BIT_LV   = 3;
  localparam int unsigned BIT_CKOE = 8;
  localparam int unsigned BIT_CKOS = 9;

  // Cause vector order: {lv, ext, por, wdr}
  function automatic logic [3:0] pick_cause(input logic por, input logic lv,
                                            input logic ext, input logic wd);
    logic [3:0] c;
    c = 4'b0000;
    if (por)      c[BIT_POR] = 1'b1;
    else if (lv)  c[BIT_LV]  = 1'b1;
    else if (ext) c[BIT_EXT] = 1'b1;
    else if (wd)  c[BIT_WDR] = 1'b1;
    return c;
  endfunction

  function automatic logic [31:0] pack_word(input logic [3:0] cause,
                                            input logic ckoe, input logic ckos);
    logic [31:0] w;
    w = '0;
    w[3:0]     = cause;
    w[BIT_CKOE] = ckoe;
    w[BIT_CKOS] = ckos;
    return w;
  endfunction

  // Stretch-counter value seen just before the boot-pin capture edge
  function automatic int unsigned capture_slot(input int unsigned stretch,
                                               input int unsigned lead);
    return stretch - lead - 1;
  endfunction
endpackage

// File: rtl/rstseq_qualifier.sv
module rstseq_qualifier #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic pin_act,
  output logic qual_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                  cnt_q <= '0;
    else if (!pin_act)          cnt_q <= '0;
    else if (cnt_q != CW'(HOLD)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CW'(HOLD));

  // R2
  qual_needs_pin_chk: assert property (@(posedge clk) disable iff (por_i)
    qual_o |-> $past(pin_act));
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch
  import rstseq_pkg::*;
#(
  parameter int unsigned STRETCH = 8,
  parameter int unsigned LEAD    = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic req_i,
  input  logic mode_pin_i,
  output logic core_rst_o,
  output logic capture_o,
  output logic boot_mode_o
);
  localparam int unsigned SW = $clog2(STRETCH + 1);
  localparam int unsigned CAP_AT = capture_slot(STRETCH, LEAD);
  logic [SW-1:0] scnt_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)                      scnt_q <= '0;
    else if (req_i)                 scnt_q <= '0;
    else if (scnt_q != SW'(STRETCH)) scnt_q <= scnt_q + 1'b1;
  end

  assign core_rst_o = (scnt_q != SW'(STRETCH));
  assign capture_o  = !req_i && (scnt_q == SW'(CAP_AT));

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)          boot_mode_o <= 1'b0;
    else if (capture_o) boot_mode_o <= mode_pin_i;
  end

  // R4
  req_holds_reset_chk: assert property (@(posedge clk) disable iff (por_i)
    req_i |=> core_rst_o);
  // R3
  release_quiet_chk: assert property (@(posedge clk) disable iff (por_i)
    $fell(core_rst_o) |-> !$past(req_i));
  // R5
  boot_hold_chk: assert property (@(posedge clk) disable iff (por_i)
    !capture_o |=> $stable(boot_mode_o));
  // R5
  capture_in_reset_chk: assert property (@(posedge clk) disable iff (por_i)
    capture_o |=> core_rst_o);
endmodule

// File: rtl/rstseq_cfg_reg.sv
module rstseq_cfg_reg
  import rstseq_pkg::*;
(
  input  logic        clk,
  input  logic        por_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        cause_evt_i,
  input  logic [3:0]  cause_vec_i,
  input  logic        pin_qual_i,
  output logic [31:0] rdata_o,
  output logic        ckoe_o,
  output logic        ckos_o
);
  logic [3:0] status_q;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      status_q <= 4'b0000;
      status_q[BIT_POR] <= 1'b1;
    end else if (cause_evt_i) status_q <= cause_vec_i;
    else if (wr_i)            status_q <= 4'b0000;
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)     ckoe_o <= 1'b0;
    else if (wr_i) ckoe_o <= wdata_i[BIT_CKOE];
  end

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i)           ckos_o <= 1'b0;
    else if (pin_qual_i) ckos_o <= 1'b0;
    else if (wr_i)       ckos_o <= wdata_i[BIT_CKOS];
  end

  assign rdata_o = pack_word(status_q, ckoe_o, ckos_o);

  // R6
  single_cause_chk: assert property (@(posedge clk) disable iff (por_i)
    $onehot0(status_q));
  // R7
  write_clears_chk: assert property (@(posedge clk) disable iff (por_i)
    (wr_i && !cause_evt_i) |=> (status_q == 4'b0000));
  // R8
  pin_clears_sel_chk: assert property (@(posedge clk) disable iff (por_i)
    pin_qual_i |=> !ckos_o);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES    = 4,
  parameter int unsigned STRETCH_CYCLES = 8,
  parameter int unsigned MODE_LEAD      = 4
) (
  input  logic        clk_slow,
  input  logic        por_i,
  input  logic        ext_rst_n,
  input  logic        lv_rst_n,
  input  logic        wdog_req,
  input  logic        boot_pin,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        core_rst,
  output logic        rst_out_n,
  output logic        boot_sel,
  output logic        clkout_en,
  output logic        clkout_sel
);
  localparam int unsigned NPINS = 2;  // index 0: external, 1: low-voltage

  logic [NPINS-1:0] pin_act;
  logic [NPINS-1:0] pin_qual;
  logic             req_any;
  logic             req_prev_q;
  logic             cause_evt;
  logic [3:0]       cause_vec;
  logic             mode_capture;

  assign pin_act = {~lv_rst_n, ~ext_rst_n};

  for (genvar g = 0; g < NPINS; g++) begin : g_qual
    rstseq_qualifier #(.HOLD(QUAL_CYCLES)) i_qual (
      .clk     (clk_slow),
      .por_i   (por_i),
      .pin_act (pin_act[g]),
      .qual_o  (pin_qual[g])
    );
  end

  assign req_any = por_i | (|pin_qual) | wdog_req;

  always_ff @(posedge clk_slow or posedge por_i) begin
    if (por_i) req_prev_q <= 1'b1;
    else       req_prev_q <= req_any;
  end

  assign cause_evt = req_any && !req_prev_q;
  assign cause_vec = pick_cause(por_i, pin_qual[1], pin_qual[0], wdog_req);

  rstseq_stretch #(.STRETCH(STRETCH_CYCLES), .LEAD(MODE_LEAD)) i_stretch (
    .clk         (clk_slow),
    .por_i       (por_i),
    .req_i       (req_any),
    .mode_pin_i  (boot_pin),
    .core_rst_o  (core_rst),
    .capture_o   (mode_capture),
    .boot_mode_o (boot_sel)
  );

  rstseq_cfg_reg i_cfg (
    .clk         (clk_slow),
    .por_i       (por_i),
    .wr_i        (cfg_wr),
    .wdata_i     (cfg_wdata),
    .cause_evt_i (cause_evt),
    .cause_vec_i (cause_vec),
    .pin_qual_i  (|pin_qual),
    .rdata_o     (cfg_rdata),
    .ckoe_o      (clkout_en),
    .ckos_o      (clkout_sel)
  );

  assign rst_out_n = ~core_rst;

  // R6
  cause_on_start_chk: assert property (@(posedge clk_slow) disable iff (por_i)
    cause_evt |=> (cfg_rdata[3:0] != 4'b0000));
  // R5
  capture_only_in_reset_chk: assert property (@(posedge clk_slow) disable iff (por_i)
    mode_capture |-> core_rst);
endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;
  logic        clk = 1'b0;
  logic        por_i, ext_rst_n, lv_rst_n, wdog_req, boot_pin, cfg_wr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        core_rst, rst_out_n, boot_sel, clkout_en, clkout_sel;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;  // 50 MHz

  reset_sequencer i_reset_sequencer (
    .clk_slow(clk), .por_i(por_i), .ext_rst_n(ext_rst_n), .lv_rst_n(lv_rst_n),
    .wdog_req(wdog_req), .boot_pin(boot_pin), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .core_rst(core_rst),
    .rst_out_n(rst_out_n), .boot_sel(boot_sel), .clkout_en(clkout_en),
    .clkout_sel(clkout_sel));

  // Vectors: source (0 watchdog, 1 external, 2 low-voltage), hold cycles,
  // expected cycles of core reset, expected status nibble
  localparam int NV = 7;
  localparam int V_SRC  [NV] = '{0, 1, 1, 2, 2, 1, 0};
  localparam int V_HOLD [NV] = '{1, 4, 3, 4, 3, 6, 3};
  localparam int V_HI   [NV] = '{8, 8, 0, 8, 0, 10, 10};
  localparam int V_STAT [NV] = '{1, 4, 0, 8, 0, 4, 1};

  int hi_cnt;
  int inv_bad;

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic tick_count();
    tick();
    if (core_rst) hi_cnt++;
    if (rst_out_n !== ~core_rst) inv_bad++;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic drive_src(input int src, input logic on);
    if (src == 0)      wdog_req  = on;
    else if (src == 1) ext_rst_n = ~on;
    else               lv_rst_n  = ~on;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    por_i = 1'b1; ext_rst_n = 1'b1; lv_rst_n = 1'b1; wdog_req = 1'b0;
    boot_pin = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    repeat (3) tick();
    chk("R1 core reset during power-on", {31'b0, core_rst}, 32'd1);
    chk("R1 word during power-on", cfg_rdata, 32'h0000_0002);
    chk("R9 reset pin during power-on", {31'b0, rst_out_n}, 32'd0);
    por_i = 1'b0;
    repeat (7) tick();
    chk("R1 still in reset after 7 edges", {31'b0, core_rst}, 32'd1);
    tick();
    chk("R1 released after 8 edges", {31'b0, core_rst}, 32'd0);
    chk("R9 reset pin released", {31'b0, rst_out_n}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      wr_word(32'h0000_0300);
      chk("R7 write loads enable/select and clears status", cfg_rdata, 32'h0000_0300);
      hi_cnt = 0; inv_bad = 0;
      drive_src(V_SRC[v], 1'b1);
      for (int k = 0; k < V_HOLD[v]; k++) tick_count();
      drive_src(V_SRC[v], 1'b0);
      repeat (20) tick_count();
      chk($sformatf("R2 R3 R4 reset length, vector %0d", v), hi_cnt, V_HI[v]);
      chk($sformatf("R6 cause, vector %0d", v), {28'b0, cfg_rdata[3:0]}, V_STAT[v]);
      chk($sformatf("R8 select, vector %0d", v), {31'b0, clkout_sel},
          (V_SRC[v] != 0 && V_HI[v] != 0) ? 32'd0 : 32'd1);
      chk($sformatf("R8 enable kept, vector %0d", v), {31'b0, clkout_en}, 32'd1);
      chk($sformatf("R9 inverse pin, vector %0d", v), inv_bad, 32'd0);
    end

    chk("R6 last cause visible", cfg_rdata, 32'h0000_0301);
    wr_word(32'hFFFF_FFFF);
    chk("R7 other bits read zero", cfg_rdata, 32'h0000_0300);
    wr_word(32'h0000_0000);
    chk("R7 clear word", cfg_rdata, 32'h0000_0000);

    // R3: request during stretch restarts the count
    hi_cnt = 0; inv_bad = 0;
    wdog_req = 1'b1; tick_count(); wdog_req = 1'b0;
    repeat (3) tick_count();
    wdog_req = 1'b1; tick_count(); wdog_req = 1'b0;
    repeat (20) tick_count();
    chk("R3 restart lengthens reset", hi_cnt, 32'd12);

    // R5: boot pin high only at the capture edge
    wdog_req = 1'b1; tick(); wdog_req = 1'b0;
    repeat (3) tick();
    boot_pin = 1'b1; tick(); boot_pin = 1'b0;
    repeat (10) tick();
    chk("R5 capture edge value 1", {31'b0, boot_sel}, 32'd1);

    // R5: boot pin low only at the capture edge
    boot_pin = 1'b1;
    wdog_req = 1'b1; tick(); wdog_req = 1'b0;
    repeat (3) tick();
    boot_pin = 1'b0; tick(); boot_pin = 1'b1;
    repeat (10) tick();
    boot_pin = 1'b0;
    chk("R5 capture edge value 0", {31'b0, boot_sel}, 32'd0);

    // R6 priority with both pins qualifying together; R8 select cleared
    wr_word(32'h0000_0300);
    ext_rst_n = 1'b0; lv_rst_n = 1'b0;
    repeat (5) tick();
    ext_rst_n = 1'b1; lv_rst_n = 1'b1;
    repeat (20) tick();
    chk("R6 low-voltage wins over external", cfg_rdata, 32'h0000_0108);

    // R1: power-on in mid-run clears enable and records power-on
    por_i = 1'b1;
    repeat (2) tick();
    chk("R1 power-on clears enable", cfg_rdata, 32'h0000_0002);
    chk("R1 core reset on power-on", {31'b0, core_rst}, 32'd1);
    por_i = 1'b0;
    repeat (10) tick();

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule